// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits between the read path of a nonvolatile array and the byte that goes out on the data bus. The operation sequencer starts a program or an erase. A clock-count timer then holds the block busy for a parameterised number of cycles, standing in for the internally timed operation. While the block is busy, a read does not return plain array contents. It returns status bits, so software can poll for completion at any point in the operation.

During a program, a read of the address being programmed returns the inverse of bit 7 of the byte being loaded. A read of any other address returns the array value on bit 7. During an erase, bit 7 always reads 0, which is the inverse of the erased value 1. Bit 6 carries a flag that flips once at the end of each completed read access while the block is busy. The remaining bits pass array data through. When the timer expires, the block emits one commit pulse. For a program, the commit carries the merged byte old AND new, because programming can only clear bits. For an erase, it is a separate erase pulse. After that, reads return true array data again.

The bus drives only when select and output-enable are low and write-enable is high, and only while the block is out of reset. An active-low reset aborts any running operation without a commit and releases the bus at once.

Top module: `opstat_reporter`

## Requirements
- R1: `dq_oe` is 1 exactly when `rst_n`=1, `cs_n`=0, `oe_n`=0 and `we_n`=1, in the same cycle and with no register in the path. While `dq_oe` is 0, `dq_out` is all zeros.
- R2: A start (`op_start`=1 while not busy) makes `busy` rise at the next clock edge. `busy` then stays high for exactly PGM_CYCLES cycles when `op_kind`=0 (program), or ERASE_CYCLES cycles when `op_kind`=1 (erase).
- R3: A start presented while `busy` is 1 is ignored. The running operation keeps its kind, address, data and end time.
- R4: While a program is busy, a read whose `bus_addr` equals the programmed address returns the inverse of bit 7 of the program data on bit 7, the toggle flag on bit 6, and `array_q[5:0]` on bits 5..0.
- R5: The toggle flag is 0 after reset. It inverts at the first clock edge that samples the read condition of R1 false after an edge that sampled it true, but only while `busy` is 1.
- R6: While not busy, an enabled read returns `array_q` unchanged on all bits.
- R7: In the last busy cycle of a program, `cell_we` is 1 for exactly one cycle, with `cell_addr` equal to the programmed address and `cell_wdata` equal to the captured old byte AND the program data.
- R8: While an erase is busy, a read returns 0 on bit 7 at any address, the toggle flag on bit 6, and `array_q[5:0]` below. In its last busy cycle, `erase_done` is 1 for one cycle and `cell_we` stays 0.
- R9: `rst_n`=0 clears `busy` and the bus enable at once, and the aborted operation produces neither `cell_we` nor `erase_done`.
- R10: While a program is busy, a read at any other address returns `array_q[7]` on bit 7 and the toggle flag on bit 6.
- R11: The toggle flag does not change while the block is idle, so enabled reads on an idle block never expose it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts the operation and releases the bus |
| cs_n | input | 1 | Bus select, active low |
| oe_n | input | 1 | Bus output enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| bus_addr | input | AW | Address of the current bus access |
| array_q | input | DW | Array byte at `bus_addr` |
| op_start | input | 1 | Sequencer request to begin an operation |
| op_kind | input | 1 | 0 = program, 1 = erase |
| op_addr | input | AW | Address being programmed |
| op_data | input | DW | Byte being programmed |
| op_old | input | DW | Stored byte at `op_addr` when the operation starts |
| dq_out | output | DW | Byte driven to the data bus |
| dq_oe | output | 1 | Data bus output enable |
| busy | output | 1 | Timed operation in progress |
| cell_we | output | 1 | One-cycle program commit |
| cell_addr | output | AW | Commit address |
| cell_wdata | output | DW | Commit data, old AND new |
| erase_done | output | 1 | One-cycle erase completion |

## Verification
A wrong internal state shows up at the ports quickly. A timer that is off by one moves the fall of `busy` and the commit pulse, and the reference model sees that in the very cycle it happens. A toggle flag that flips at the wrong time, or flips while idle, shows as a wrong bit 6 on the next busy read. A wrong captured address or data byte corrupts bit 7 on the first poll of that address, and `cell_wdata` at the commit. The bench compares every output against a behavioural model on every clock, so any of these errors is reported within one cycle of becoming visible.

// File: rtl/opstat_pkg.sv
package opstat_pkg;
  parameter int DW = 8;

  typedef enum logic {KIND_PROG = 1'b0, KIND_ERASE = 1'b1} op_kind_e;

  // Programming can only clear bits: the result keeps a 1 only where both are 1.
  function automatic logic [DW-1:0] merge_program(input logic [DW-1:0] old_b,
                                                  input logic [DW-1:0] new_b);
    return old_b & new_b;
  endfunction

  // Byte returned by a read while an operation is busy.
  function automatic logic [DW-1:0] poll_byte(input op_kind_e        kind,
                                              input logic            addr_hit,
                                              input logic [DW-1:0]   loaded,
                                              input logic [DW-1:0]   arr,
                                              input logic            tog);
    logic [DW-1:0] b;
    b    = arr;
    b[6] = tog;
    if (kind == KIND_ERASE)  b[7] = 1'b0;
    else if (addr_hit)       b[7] = ~loaded[7];
    return b;
  endfunction
endpackage

// File: rtl/opstat_timer.sv
module opstat_timer #(
  parameter int PGM_CYCLES   = 6,
  parameter int ERASE_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic kind,
  output logic busy,
  output logic done,
  output logic accept,
  output logic kind_q
);
  localparam int MAXC = (PGM_CYCLES > ERASE_CYCLES) ? PGM_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PGM_LOAD   = CW'(PGM_CYCLES - 1);
  localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign accept = start && !busy;
  assign done   = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      kind_q <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start) begin
      busy   <= 1'b1;
      kind_q <= kind;
      cnt    <= kind ? ERASE_LOAD : PGM_LOAD;
    end
  end
endmodule

// File: rtl/opstat_toggle.sv
module opstat_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_act,
  input  logic busy,
  output logic tog,
  output logic rd_end
);
  logic rd_q;

  assign rd_end = rd_q && !rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      tog  <= 1'b0;
    end else begin
      rd_q <= rd_act;
      if (busy && rd_end) tog <= ~tog;
    end
  end
endmodule

// File: rtl/opstat_reporter.sv
module opstat_reporter #(
  parameter int AW           = 17,
  parameter int PGM_CYCLES   = 6,
  parameter int ERASE_CYCLES = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cs_n,
  input  logic                        oe_n,
  input  logic                        we_n,
  input  logic [AW-1:0]               bus_addr,
  input  logic [opstat_pkg::DW-1:0]   array_q,
  input  logic                        op_start,
  input  logic                        op_kind,
  input  logic [AW-1:0]               op_addr,
  input  logic [opstat_pkg::DW-1:0]   op_data,
  input  logic [opstat_pkg::DW-1:0]   op_old,
  output logic [opstat_pkg::DW-1:0]   dq_out,
  output logic                        dq_oe,
  output logic                        busy,
  output logic                        cell_we,
  output logic [AW-1:0]               cell_addr,
  output logic [opstat_pkg::DW-1:0]   cell_wdata,
  output logic                        erase_done
);
  import opstat_pkg::*;

  // Named internal events, visible to the bound checker
  logic            rd_act;
  logic            done;
  logic            accept;
  logic            kind_q;
  logic            tog;
  logic            rd_end;
  logic            addr_hit;
  logic [AW-1:0]   lat_addr;
  logic [DW-1:0]   lat_data;
  logic [DW-1:0]   lat_old;

  assign rd_act = rst_n && !cs_n && !oe_n && we_n;

  opstat_timer #(.PGM_CYCLES(PGM_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (op_start),
    .kind   (op_kind),
    .busy   (busy),
    .done   (done),
    .accept (accept),
    .kind_q (kind_q)
  );

  opstat_toggle u_toggle (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_act (rd_act),
    .busy   (busy),
    .tog    (tog),
    .rd_end (rd_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr <= '0;
      lat_data <= '0;
      lat_old  <= '0;
    end else if (accept) begin
      lat_addr <= op_addr;
      lat_data <= op_data;
      lat_old  <= op_old;
    end
  end

  assign addr_hit = (bus_addr == lat_addr);

  always_comb begin
    dq_out = '0;
    if (rd_act) begin
      if (busy) dq_out = poll_byte(op_kind_e'(kind_q), addr_hit, lat_data, array_q, tog);
      else      dq_out = array_q;
    end
  end

  assign dq_oe      = rd_act;
  assign cell_we    = done && (op_kind_e'(kind_q) == KIND_PROG);
  assign erase_done = done && (op_kind_e'(kind_q) == KIND_ERASE);
  assign cell_addr  = lat_addr;
  assign cell_wdata = merge_program(lat_old, lat_data);
endmodule

// File: rtl/opstat_checker.sv
module opstat_checker #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          oe_n,
  input logic          we_n,
  input logic [7:0]    dq_out,
  input logic          dq_oe,
  input logic [7:0]    array_q,
  input logic          busy,
  input logic          done,
  input logic          tog,
  input logic          kind_q,
  input logic          cell_we,
  input logic          erase_done,
  input logic          op_start,
  input logic [AW-1:0] lat_addr
);
  a_r1_bus_off_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !oe_n == 1'b0 || !we_n) |-> (!dq_oe && dq_out == 8'h00));

  a_r2_busy_holds_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  a_r2_busy_drops_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r3_start_ignored_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_start) |=> ($stable(lat_addr) && $stable(kind_q)));

  a_r6_idle_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && dq_oe) |-> (dq_out == array_q));

  a_r7_commit_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cell_we |=> !cell_we);

  a_r8_one_completion_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cell_we, erase_done}));

  a_r8_erase_bit7_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_q && dq_oe) |-> (dq_out[7] == 1'b0));

  a_r11_toggle_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(tog));
endmodule

bind opstat_reporter opstat_checker #(.AW(AW)) u_opstat_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .oe_n       (oe_n),
  .we_n       (we_n),
  .dq_out     (dq_out),
  .dq_oe      (dq_oe),
  .array_q    (array_q),
  .busy       (busy),
  .done       (done),
  .tog        (tog),
  .kind_q     (kind_q),
  .cell_we    (cell_we),
  .erase_done (erase_done),
  .op_start   (op_start),
  .lat_addr   (lat_addr)
);

// File: tb/test_opstat_reporter.sv
`timescale 1ns/1ps
module test_opstat_reporter;
  localparam int AW = 17;
  localparam int PC = 6;
  localparam int EC = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    array_q;
  logic          op_start = 1'b0, op_kind = 1'b0;
  logic [AW-1:0] op_addr = '0;
  logic [7:0]    op_data = '0, op_old = '0;
  logic [7:0]    dq_out;
  logic          dq_oe, busy, cell_we, erase_done;
  logic [AW-1:0] cell_addr;
  logic [7:0]    cell_wdata;

  always #5 clk = ~clk;

  // Array stand-in: a fixed pattern derived from the address
  assign array_q = bus_addr[7:0] ^ 8'hA6;

  opstat_reporter #(.AW(AW), .PGM_CYCLES(PC), .ERASE_CYCLES(EC)) i_opstat_reporter (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .bus_addr(bus_addr), .array_q(array_q), .op_start(op_start), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .op_old(op_old), .dq_out(dq_out),
    .dq_oe(dq_oe), .busy(busy), .cell_we(cell_we), .cell_addr(cell_addr),
    .cell_wdata(cell_wdata), .erase_done(erase_done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit          m_busy = 0;
  bit          m_kind = 0;
  int          m_left = 0;
  bit          m_tog = 0;
  bit          m_rdprev = 0;
  logic [AW-1:0] m_addr = '0;
  logic [7:0]  m_data = '0, m_old = '0;

  function automatic bit reading();
    return rst_n && !cs_n && !oe_n && we_n;
  endfunction

  always @(posedge clk) begin
    bit rd_now;
    rd_now = reading();
    if (!rst_n) begin
      m_busy = 0; m_left = 0; m_tog = 0; m_rdprev = 0; m_kind = 0;
      m_addr = '0; m_data = '0; m_old = '0;
    end else begin
      if (m_busy && m_rdprev && !rd_now) m_tog = ~m_tog;
      m_rdprev = rd_now;
      if (m_busy) begin
        m_left = m_left - 1;
        if (m_left == 0) m_busy = 0;
      end else if (op_start) begin
        m_busy = 1; m_kind = op_kind; m_left = op_kind ? EC : PC;
        m_addr = op_addr; m_data = op_data; m_old = op_old;
      end
    end
    #4;
    compare_all();
  end

  task automatic compare_all();
    bit rd, fin;
    logic [7:0] exp_dq;
    string tag;
    rd  = reading();
    fin = m_busy && (m_left == 1);
    exp_dq = 8'h00;
    tag = "R1";
    if (rd) begin
      exp_dq = array_q;
      tag = "R6";
      if (m_busy) begin
        exp_dq[6] = m_tog;
        if (m_kind) begin
          exp_dq[7] = 1'b0; tag = "R8,R5";
        end else if (bus_addr == m_addr) begin
          exp_dq[7] = ~m_data[7]; tag = "R4,R5";
        end else tag = "R10,R5";
      end
    end
    check("R1 dq_oe", dq_oe, rd);
    check({tag, " dq_out"}, dq_out, exp_dq);
    check("R2,R3,R9 busy", busy, m_busy);
    check("R7,R9 cell_we", cell_we, fin && !m_kind);
    check("R8,R9 erase_done", erase_done, fin && m_kind);
    if (fin && !m_kind) begin
      check("R7 cell_addr", cell_addr, m_addr);
      check("R7 cell_wdata", cell_wdata, m_old & m_data);
    end
  endtask

  // Stimulus: all inputs change on the falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, input int hold);
    @(negedge clk); bus_addr = a; cs_n = 0; oe_n = 0; we_n = 1;
    idle(hold);
    cs_n = 1; oe_n = 1;
  endtask

  task automatic start(input bit k, input logic [AW-1:0] a, input logic [7:0] d, input logic [7:0] o);
    @(negedge clk); op_start = 1; op_kind = k; op_addr = a; op_data = d; op_old = o;
    @(negedge clk); op_start = 0;
  endtask

  initial begin
    idle(2);
    // R9, R11: reset state, bus released, nothing busy
    check("R9 reset dq_oe", dq_oe, 0);
    check("R9 reset busy", busy, 0);
    @(negedge clk); rst_n = 1;
    // R6 idle reads; R1 blocked cases
    rd(17'h00120, 1);
    rd(17'h1C002, 2);
    @(negedge clk); cs_n = 0; oe_n = 0; we_n = 0; bus_addr = 17'h00033;
    @(negedge clk); cs_n = 0; oe_n = 1; we_n = 1;
    @(negedge clk); cs_n = 1; oe_n = 0;
    @(negedge clk); cs_n = 1; oe_n = 1;
    // R4, R5, R10, R7: program with bit7 data = 1, polling both addresses
    start(0, 17'h04010, 8'hB3, 8'hF5);
    rd(17'h04010, 1);
    rd(17'h04010, 2);
    rd(17'h00111, 1);
    idle(4);
    rd(17'h04010, 1);
    // R4: bit7 data = 0, continuous reads across completion
    start(0, 17'h18000, 8'h25, 8'h6F);
    rd(17'h18000, 9);
    idle(2);
    // R3: second start while busy is ignored
    start(0, 17'h00200, 8'h80, 8'hFF);
    start(1, 17'h00300, 8'h00, 8'h00);
    rd(17'h00200, 1);
    idle(6);
    // R8: erase with reads at several addresses
    start(1, 17'h0A000, 8'h00, 8'h00);
    rd(17'h0A000, 1);
    rd(17'h1FFFF, 3);
    rd(17'h00005, 1);
    idle(EC);
    // R9: reset in the middle of a program, then a clean read
    start(0, 17'h00042, 8'h0F, 8'hFF);
    rd(17'h00042, 1);
    @(negedge clk); rst_n = 0;
    idle(2);
    rst_n = 1;
    idle(PC + 2);
    // R11: toggle restarts at 0 after reset
    start(0, 17'h00050, 8'h7E, 8'hC3);
    rd(17'h00050, 1);
    idle(PC + 2);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule